// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block is a small translation cache placed between a processor and memory. It turns a 32-bit virtual address into a 32-bit physical address using 4 KB pages. It keeps eight entries. Each entry holds a virtual page number as an explicit tag, a physical frame number and three permission bits. Every entry is searched at the same time. A lookup ends in one of three results: a hit that carries the physical address, a protection fault, or a miss. On a miss the requester has to fetch the entry from the page table in memory.

Lookups enter through a valid/ready request channel. Results leave through a valid/ready response channel with one cycle of latency. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low only while a result is waiting and `rsp_ready` is low. A waiting result holds its value until it is taken. Entries are loaded through a plain refill port, and the caller chooses the slot. The caller also walks the page table and picks which slot to replace.

Each entry records whether it has been used and whether it has been written. Software can clear the used flags in all entries at once, and can read any entry's flags through a peek port.

Top module: `xlat_cache`

## Requirements
- R1: On a hit, `rsp_paddr` is the stored frame number in bits 31:12 and the request's bits 11:0 in bits 11:0. The virtual page number is bits 31:12 of `req_vaddr`.
- R2: A request whose page number matches no valid entry returns status 1 (miss), with `rsp_paddr` zero. Status 0 means hit and status 2 means fault. Status 3 never appears.
- R3: A refill (`fill_en`) writes tag, frame and permissions into slot `fill_slot` only. It marks that slot valid and clears its used and written flags. Every other slot is left unchanged.
- R4: `fill_perm` bit 0 grants read, bit 1 grants write and bit 2 grants execute. `req_kind` 0 is read, 1 is write and 2 is execute. Kind 3 is never permitted. A matching access without permission returns status 2 with `rsp_paddr` zero.
- R5: A permitted hit sets the matching entry's used flag. A permitted write hit also sets its written flag. A fault or a miss changes no flag.
- R6: When several valid entries match, the entry with the lowest index decides the result and is the only one whose flags change.
- R7: A one-cycle `flush` pulse makes every entry invalid at the next edge. Flush takes priority over a refill in the same cycle.
- R8: A `clr_ref` pulse clears the used flag in every entry and leaves the written flags as they are. A permitted hit in the same cycle still sets its own entry's used flag.
- R9: A request accepted on a clock edge makes `rsp_valid` high after that edge. The flag updates take effect on the same edge.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response holds its value. A new request can be accepted in the same cycle as the response is taken.
- R11: After reset, every entry is invalid, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Lookup result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_status | output | 2 | 0 hit, 1 miss, 2 fault |
| rsp_paddr | output | 32 | Physical address on a hit, otherwise zero |
| fill_en | input | 1 | Refill strobe |
| fill_slot | input | 3 | Slot to overwrite |
| fill_vpn | input | 20 | Virtual page tag for the refill |
| fill_pfn | input | 20 | Physical frame number for the refill |
| fill_perm | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| flush | input | 1 | Invalidate every entry |
| clr_ref | input | 1 | Clear every used flag |
| peek_slot | input | 3 | Slot whose state is shown on the peek outputs |
| peek_valid | output | 1 | Valid bit of the peeked slot |
| peek_ref | output | 1 | Used flag of the peeked slot |
| peek_mod | output | 1 | Written flag of the peeked slot |

## Verification
The bench loads all eight slots so that the slots together cover every one of the eight permission patterns. It then looks up every slot with all four access kinds, which separates correct permission decoding from off-by-one bit ordering and catches kind 3 leaking through. Page numbers next to the loaded tags test whether the tag compare uses every bit. Two slots loaded with the same tag but different frames and permissions show whether the lowest index wins. Flag state is read back through the peek port after a lone clear, after a clear in the same cycle as a hit, after a refill, and after a flush. A held response under back-pressure shows whether the result stays stable and whether the queued request is accepted on the release edge.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    RSP_HIT   = 2'd0,
    RSP_MISS  = 2'd1,
    RSP_FAULT = 2'd2
  } rsp_code_e;

  localparam int PERM_BITS = 3;
  localparam int PERM_RD   = 0;
  localparam int PERM_WR   = 1;
  localparam int PERM_EX   = 2;

  // Returns 1 when the permission field allows the access kind.
  function automatic logic perm_ok(input logic [1:0] kind, input logic [PERM_BITS-1:0] perm);
    case (kind)
      ACC_READ:  perm_ok = perm[PERM_RD];
      ACC_WRITE: perm_ok = perm[PERM_WR];
      ACC_EXEC:  perm_ok = perm[PERM_EX];
      default:   perm_ok = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/xlat_slots.sv
module xlat_slots
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                fill_en,
  input  logic [IDX_W-1:0]                    fill_slot,
  input  logic [VPN_W-1:0]                    fill_vpn,
  input  logic [PFN_W-1:0]                    fill_pfn,
  input  logic [PERM_BITS-1:0]                fill_perm,
  input  logic                                flush,
  input  logic                                clr_ref,
  input  logic                                touch_en,
  input  logic [IDX_W-1:0]                    touch_slot,
  input  logic                                touch_write,
  output logic [ENTRIES-1:0]                  valid_o,
  output logic [ENTRIES-1:0][VPN_W-1:0]       vpn_o,
  output logic [ENTRIES-1:0][PFN_W-1:0]       pfn_o,
  output logic [ENTRIES-1:0][PERM_BITS-1:0]   perm_o,
  output logic [ENTRIES-1:0]                  ref_o,
  output logic [ENTRIES-1:0]                  mod_o
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic fill_here, touch_here;
    assign fill_here  = fill_en  && (fill_slot  == IDX_W'(g));
    assign touch_here = touch_en && (touch_slot == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_o[g] <= 1'b0;
        vpn_o[g]   <= '0;
        pfn_o[g]   <= '0;
        perm_o[g]  <= '0;
        ref_o[g]   <= 1'b0;
        mod_o[g]   <= 1'b0;
      end else if (flush) begin
        valid_o[g] <= 1'b0;
        ref_o[g]   <= 1'b0;
        mod_o[g]   <= 1'b0;
      end else if (fill_here) begin
        valid_o[g] <= 1'b1;
        vpn_o[g]   <= fill_vpn;
        pfn_o[g]   <= fill_pfn;
        perm_o[g]  <= fill_perm;
        ref_o[g]   <= 1'b0;
        mod_o[g]   <= 1'b0;
      end else if (touch_here) begin
        ref_o[g] <= 1'b1;
        if (touch_write) mod_o[g] <= 1'b1;
      end else if (clr_ref) begin
        ref_o[g] <= 1'b0;
      end
    end
  end

  assert_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_o == '0));

  assert_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> (valid_o[$past(fill_slot)] && !ref_o[$past(fill_slot)]
                             && !mod_o[$past(fill_slot)]));

  assert_touch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en && !flush && !(fill_en && fill_slot == touch_slot))
      |=> ref_o[$past(touch_slot)]);

  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ref && !touch_en) |=> (ref_o == '0));

  assert_keep_mod_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ref && !touch_en && !fill_en && !flush) |=> $stable(mod_o));

endmodule

// File: rtl/xlat_lookup.sv
module xlat_lookup
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [VPN_W-1:0]                    q_vpn,
  input  logic [1:0]                          q_kind,
  input  logic [ENTRIES-1:0]                  valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]       vpn_i,
  input  logic [ENTRIES-1:0][PFN_W-1:0]       pfn_i,
  input  logic [ENTRIES-1:0][PERM_BITS-1:0]   perm_i,
  output logic                                hit_o,
  output logic [IDX_W-1:0]                    idx_o,
  output logic [PFN_W-1:0]                    pfn_o,
  output logic                                allowed_o
);

  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] grant;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (vpn_i[g] == q_vpn);
  end

  // Scan from the top so that the lowest matching index is left standing.
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    grant = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
        grant = ENTRIES'(1) << i;
      end
    end
  end

  assign pfn_o     = pfn_i[idx_o];
  assign allowed_o = perm_ok(q_kind, perm_i[idx_o]);

  assert_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ($onehot(grant) && grant[idx_o] && match[idx_o]));

  assert_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> ((match & ((ENTRIES'(1) << idx_o) - ENTRIES'(1))) == '0));

  assert_nohit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> (grant == '0));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int PFN_W    = PA_W - PAGE_BITS,
  localparam int IDX_W    = $clog2(ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [VA_W-1:0]       req_vaddr,
  input  logic [1:0]            req_kind,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [1:0]            rsp_status,
  output logic [PA_W-1:0]       rsp_paddr,
  input  logic                  fill_en,
  input  logic [IDX_W-1:0]      fill_slot,
  input  logic [VPN_W-1:0]      fill_vpn,
  input  logic [PFN_W-1:0]      fill_pfn,
  input  logic [PERM_BITS-1:0]  fill_perm,
  input  logic                  flush,
  input  logic                  clr_ref,
  input  logic [IDX_W-1:0]      peek_slot,
  output logic                  peek_valid,
  output logic                  peek_ref,
  output logic                  peek_mod
);

  logic [ENTRIES-1:0]                 valid_v, ref_v, mod_v;
  logic [ENTRIES-1:0][VPN_W-1:0]      vpn_v;
  logic [ENTRIES-1:0][PFN_W-1:0]      pfn_v;
  logic [ENTRIES-1:0][PERM_BITS-1:0]  perm_v;

  logic              hit, allowed, accept, touch_en;
  logic [IDX_W-1:0]  hit_idx;
  logic [PFN_W-1:0]  hit_pfn;
  logic [VPN_W-1:0]  q_vpn;
  logic [PAGE_BITS-1:0] q_off;

  assign q_vpn     = req_vaddr[VA_W-1:PAGE_BITS];
  assign q_off     = req_vaddr[PAGE_BITS-1:0];
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign touch_en  = accept && hit && allowed;

  xlat_lookup #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_lookup (
    .clk(clk), .rst_n(rst_n),
    .q_vpn(q_vpn), .q_kind(req_kind),
    .valid_i(valid_v), .vpn_i(vpn_v), .pfn_i(pfn_v), .perm_i(perm_v),
    .hit_o(hit), .idx_o(hit_idx), .pfn_o(hit_pfn), .allowed_o(allowed)
  );

  xlat_slots #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_slot(fill_slot), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_perm(fill_perm),
    .flush(flush), .clr_ref(clr_ref),
    .touch_en(touch_en), .touch_slot(hit_idx),
    .touch_write(req_kind == ACC_WRITE),
    .valid_o(valid_v), .vpn_o(vpn_v), .pfn_o(pfn_v), .perm_o(perm_v),
    .ref_o(ref_v), .mod_o(mod_v)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= RSP_MISS;
      rsp_paddr  <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      if (!hit) begin
        rsp_status <= RSP_MISS;
        rsp_paddr  <= '0;
      end else if (!allowed) begin
        rsp_status <= RSP_FAULT;
        rsp_paddr  <= '0;
      end else begin
        rsp_status <= RSP_HIT;
        rsp_paddr  <= {hit_pfn, q_off};
      end
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign peek_valid = valid_v[peek_slot];
  assign peek_ref   = ref_v[peek_slot];
  assign peek_mod   = mod_v[peek_slot];

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_status) && $stable(rsp_paddr)));

  assert_offset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((rsp_status != RSP_HIT) ||
                (rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0]))));

  assert_zero_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != RSP_HIT) |-> (rsp_paddr == '0));

  assert_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_status != 2'd3));

endmodule

// File: tb/xlat_cache_test.sv
`timescale 1ns/1ps
module xlat_cache_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [1:0]  rsp_status;
  logic [31:0] rsp_paddr;
  logic        fill_en = 1'b0;
  logic [2:0]  fill_slot = '0;
  logic [19:0] fill_vpn = '0;
  logic [19:0] fill_pfn = '0;
  logic [2:0]  fill_perm = '0;
  logic        flush = 1'b0;
  logic        clr_ref = 1'b0;
  logic [2:0]  peek_slot = '0;
  logic        peek_valid, peek_ref, peek_mod;

  always #10 clk = ~clk;

  xlat_cache uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_kind(req_kind),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_status(rsp_status), .rsp_paddr(rsp_paddr),
    .fill_en(fill_en), .fill_slot(fill_slot), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_perm(fill_perm), .flush(flush), .clr_ref(clr_ref),
    .peek_slot(peek_slot), .peek_valid(peek_valid), .peek_ref(peek_ref), .peek_mod(peek_mod)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Bench-side model of the entries, built from the requirements.
  logic [19:0] m_vpn [8];
  logic [19:0] m_pfn [8];
  logic [2:0]  m_perm[8];
  logic        m_val [8];
  logic        m_ref [8];
  logic        m_mod [8];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  function automatic logic kind_ok(input logic [1:0] k, input logic [2:0] p);
    return (k == 2'd3) ? 1'b0 : p[k];
  endfunction

  // Expected result and model update for one accepted lookup.
  task automatic model_lookup(input logic [31:0] va, input logic [1:0] k, input bit clr,
                              output logic [1:0] st, output logic [31:0] pa);
    int win = -1;
    for (int i = 0; i < 8; i++)
      if (win < 0 && m_val[i] && m_vpn[i] == va[31:12]) win = i;
    if (clr) for (int i = 0; i < 8; i++) m_ref[i] = 1'b0;
    if (win < 0) begin
      st = 2'd1; pa = '0;
    end else if (!kind_ok(k, m_perm[win])) begin
      st = 2'd2; pa = '0;
    end else begin
      st = 2'd0; pa = {m_pfn[win], va[11:0]};
      m_ref[win] = 1'b1;
      if (k == 2'd1) m_mod[win] = 1'b1;
    end
  endtask

  task automatic lookup_chk(input logic [31:0] va, input logic [1:0] k, input bit clr, input string req);
    logic [1:0]  est;
    logic [31:0] epa;
    model_lookup(va, k, clr, est, epa);
    @(negedge clk);
    req_vaddr = va; req_kind = k; req_valid = 1'b1; clr_ref = clr; rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; clr_ref = 1'b0;
    chk(rsp_valid == 1'b1, "R9 response one cycle after accept", {31'b0, rsp_valid}, 32'd1);
    chk(rsp_status == est, req, {30'b0, rsp_status}, {30'b0, est});
    chk(rsp_paddr == epa, req, rsp_paddr, epa);
  endtask

  task automatic fill(input int s, input logic [19:0] v, input logic [19:0] p, input logic [2:0] pm);
    @(negedge clk);
    fill_en = 1'b1; fill_slot = 3'(s); fill_vpn = v; fill_pfn = p; fill_perm = pm;
    @(negedge clk);
    fill_en = 1'b0;
    m_vpn[s] = v; m_pfn[s] = p; m_perm[s] = pm; m_val[s] = 1'b1; m_ref[s] = 1'b0; m_mod[s] = 1'b0;
  endtask

  task automatic peek_all(input string req);
    for (int i = 0; i < 8; i++) begin
      peek_slot = 3'(i);
      #1;
      chk(peek_valid == m_val[i], req, {31'b0, peek_valid}, {31'b0, m_val[i]});
      chk(peek_ref == m_ref[i], req, {31'b0, peek_ref}, {31'b0, m_ref[i]});
      chk(peek_mod == m_mod[i], req, {31'b0, peek_mod}, {31'b0, m_mod[i]});
    end
  endtask

  function automatic logic [19:0] tag_of(input int i);
    return 20'h12340 + 20'(i * 6);
  endfunction

  function automatic logic [19:0] frame_of(input int i);
    return 20'hA0000 ^ 20'(i * 32'h111);
  endfunction

  initial begin
    #(20 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_vpn[i] = '0; m_pfn[i] = '0; m_perm[i] = '0; m_val[i] = 0; m_ref[i] = 0; m_mod[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11: reset state
    chk(rsp_valid == 1'b0, "R11 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    chk(req_ready == 1'b1, "R11 req_ready after reset", {31'b0, req_ready}, 32'd1);
    peek_all("R11 entries after reset");
    lookup_chk(32'h1234_0123, 2'd0, 0, "R2 miss on empty buffer");

    // R3/R4: load all slots, permissions cover all eight patterns
    for (int i = 0; i < 8; i++) fill(i, tag_of(i), frame_of(i), 3'(i));
    peek_all("R3 entries after refill");

    // R1/R4/R5: every slot with every access kind
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 4; k++)
        lookup_chk({tag_of(i), 12'((i * 337 + k * 1001) & 32'hFFF)}, 2'(k), 0,
                   "R1 R4 translation and permission sweep");
    peek_all("R5 flags after sweep");

    // R2: neighbouring page numbers miss
    for (int i = 0; i < 8; i++) begin
      lookup_chk({tag_of(i) + 20'd1, 12'h3C5}, 2'd0, 0, "R2 miss on adjacent tag");
      lookup_chk({tag_of(i) ^ 20'h80000, 12'h001}, 2'd0, 0, "R2 miss on top tag bit");
    end
    peek_all("R5 flags unchanged by misses");

    // R8: lone clear, then clear together with a hit on slot 3 (read allowed)
    @(negedge clk); clr_ref = 1'b1;
    @(negedge clk); clr_ref = 1'b0;
    for (int i = 0; i < 8; i++) m_ref[i] = 1'b0;
    peek_all("R8 clear keeps written flags");
    lookup_chk({tag_of(3), 12'h010}, 2'd0, 1, "R8 hit with clear");
    peek_all("R8 hit beats clear");

    // R3: overwrite slot 1, old tag gone, new tag hits, others unchanged
    fill(1, 20'h55555, 20'h0ABCD, 3'b111);
    peek_all("R3 overwrite one slot");
    lookup_chk({tag_of(1), 12'h222}, 2'd0, 0, "R3 old tag misses");
    lookup_chk({20'h55555, 12'h7FF}, 2'd1, 0, "R3 new tag hits");

    // R10: back-pressure on the response
    @(negedge clk);
    req_vaddr = {tag_of(7), 12'hABC}; req_kind = 2'd2; req_valid = 1'b1; rsp_ready = 1'b0;
    @(negedge clk);
    chk(rsp_valid && rsp_status == 2'd0, "R10 first response present", {30'b0, rsp_status}, 32'd0);
    chk(rsp_paddr == {frame_of(7), 12'hABC}, "R10 first address", rsp_paddr, {frame_of(7), 12'hABC});
    m_ref[7] = 1'b1;
    req_vaddr = {tag_of(6), 12'h00F}; req_kind = 2'd1; req_valid = 1'b1;
    #1;
    chk(req_ready == 1'b0, "R10 ready low while held", {31'b0, req_ready}, 32'd0);
    @(negedge clk);
    chk(rsp_paddr == {frame_of(7), 12'hABC}, "R10 response holds", rsp_paddr, {frame_of(7), 12'hABC});
    chk(rsp_status == 2'd0, "R10 status holds", {30'b0, rsp_status}, 32'd0);
    peek_all("R10 held request changes no flag");
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    m_ref[6] = 1'b1; m_mod[6] = 1'b1;
    chk(rsp_valid && rsp_status == 2'd0, "R10 queued request accepted at release",
        {30'b0, rsp_status}, 32'd0);
    chk(rsp_paddr == {frame_of(6), 12'h00F}, "R10 queued address", rsp_paddr, {frame_of(6), 12'h00F});
    peek_all("R5 flags after queued write");

    // R7: flush together with a refill, flush wins
    @(negedge clk);
    flush = 1'b1; fill_en = 1'b1; fill_slot = 3'd4; fill_vpn = 20'h00777; fill_perm = 3'b111;
    @(negedge clk);
    flush = 1'b0; fill_en = 1'b0;
    for (int i = 0; i < 8; i++) begin m_val[i] = 0; m_ref[i] = 0; m_mod[i] = 0; end
    peek_all("R7 flush invalidates all");
    lookup_chk({tag_of(0), 12'h000}, 2'd0, 0, "R7 miss after flush");
    lookup_chk({20'h00777, 12'h000}, 2'd0, 0, "R7 flush beats refill");

    // R6: duplicate tag in slots 5 and 2
    fill(5, 20'h0F0F0, 20'h11111, 3'b111);
    fill(2, 20'h0F0F0, 20'h22222, 3'b001);
    lookup_chk({20'h0F0F0, 12'h444}, 2'd1, 0, "R6 lowest slot decides fault");
    lookup_chk({20'h0F0F0, 12'h555}, 2'd0, 0, "R6 lowest slot frame");
    peek_all("R6 only lowest slot flagged");

    @(negedge clk);
    finish_run();
  end

endmodule